// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier with Compressed Test Mode

This block is the device-side control logic of a page-mode DRAM. A fast system clock oversamples the three active-low strobes (row strobe, column strobe, write strobe) after a two-flip-flop synchroniser. Each period in which the row strobe is low is classified by the order of the strobes, and a cycle-kind code is issued with a one-clock event pulse. Four kinds exist: an ordinary access, a row-only refresh, a counter refresh in which the column strobe leads the row strobe, and a test-mode set cycle.

The block owns a 10-bit refresh row counter that supplies the row for counter refreshes and steps after each one. It also owns a test-mode flag. While the flag is set, a read folds eight array bits into a single pass/fail level and a write copies one data bit into eight cells. The array is outside the block. It is reached through a registered row and column address, an 8-bit read word that the array returns, and an 8-bit write-enable and write-data pair that pulses for one clock per write. Address and data inputs pass through the same synchroniser depth as the strobes, so they must be stable for three clocks around each strobe edge.

Top module: `strobe_mode_ctrl`

## Requirements
- R1: Each row-strobe low period gives exactly one one-clock `cyc_evt` pulse, with `cyc_kind` encoded as 0 = access, 1 = row-only refresh, 2 = counter refresh, 3 = test-mode set. The pulse comes three clocks after the deciding strobe edge.
- R2: If the column strobe is low and the write strobe is high when the row strobe falls, a counter refresh runs. `rfsh_stb` pulses with `arr_row` equal to the counter, and the counter then steps by one, wrapping from 1023 to 0.
- R3: If the column and write strobes are both low when the row strobe falls, `test_mode` is set.
- R4: A row-only refresh or a counter refresh clears `test_mode`. An ordinary access leaves it unchanged.
- R5: If the row strobe falls with the column strobe high and rises again without any column-strobe fall, the period is a row-only refresh. It is reported at the rise, and `rfsh_stb` pulses with `arr_row` equal to the address latched at the fall.
- R6: In an ordinary access, `arr_row` takes the address at the row-strobe fall and `arr_col` takes the address at every column-strobe fall while the row strobe stays low (page mode).
- R7: A column-strobe fall with the write strobe high starts a read. `dq_oe` is high until the column strobe rises, and `dq_out` equals `rd_word[3:0]`. When `dq_oe` is low, `dq_out` is 0.
- R8: A write pulses `wr_en` = 8'h0F for one clock, with `wr_data[3:0]` = `dq_in` and `wr_data[7:4]` = 0. The write is triggered either by the write strobe being low at the column-strobe fall (early write, with `dq_oe` staying low) or by the write strobe falling while the column strobe is low (delayed write).
- R9: In test mode, a read drives all four `dq_out` lines to 1 when `rd_word` is 8'h00 or 8'hFF, and to 0 for any other value.
- R10: In test mode, a write pulses `wr_en` = 8'hFF with every `wr_data` bit equal to `dq_in[1]`.
- R11: After a counter refresh, a column-strobe rise and then a fall while the row strobe is still low perform an access. That access uses the refreshed row (the counter value before the step) and the address at the second fall as the column.
- R12: Reset clears `test_mode`, `dq_oe`, `wr_en` and the pulses, and sets the refresh counter to 0, so the first counter refresh uses row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_strobe_n | input | 1 | Row strobe, active low, asynchronous |
| col_strobe_n | input | 1 | Column strobe, active low, asynchronous |
| wr_strobe_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 10 | Multiplexed row/column address |
| dq_in | input | 4 | Write data lines |
| rd_word | input | 8 | Read word returned by the array |
| dq_out | output | 4 | Read data, 0 when not enabled |
| dq_oe | output | 1 | Read data output enable |
| arr_row | output | 10 | Row address to array |
| arr_col | output | 10 | Column address to array |
| wr_en | output | 8 | Per-cell write enable, one-clock pulse |
| wr_data | output | 8 | Per-cell write data |
| rfsh_stb | output | 1 | One-clock refresh pulse for `arr_row` |
| cyc_evt | output | 1 | One-clock cycle classification pulse |
| cyc_kind | output | 2 | Cycle kind code |
| test_mode | output | 1 | Compressed test mode flag |

## Verification
A wrong refresh counter value shows up on `arr_row` at the next counter refresh, three clocks after that row-strobe fall. It also shows up at the next counter-test access. A test-mode flag stuck in the wrong state appears on the first read or write that follows, as a folded `dq_out` or an 8'hFF `wr_en` where a 4-bit result was expected, or the reverse. A misclassified strobe order shows at the `cyc_kind` pulse of the same period. A refresh that is missed or doubled shows in the count of `rfsh_stb` pulses.

// File: rtl/strobe_mode_pkg.sv
package strobe_mode_pkg;
  typedef enum logic [1:0] {
    CYC_ACCESS = 2'd0,
    CYC_ROWREF = 2'd1,
    CYC_CNTREF = 2'd2,
    CYC_TSET   = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW,
    PH_ACC,
    PH_CNT_LOW,
    PH_CNT_HIGH,
    PH_TSET
  } phase_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int W       = 3,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= {W{RST_V}};
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row <= '0;
    else if (step) row <= row + 1'b1;
  end

  a_r2_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> row == $past(row) + 1'b1);
endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
  import strobe_mode_pkg::*;
#(
  parameter int AW   = 10,
  parameter int DQ_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras,
  input  logic            cas,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DQ_W-1:0] dq,
  input  logic [AW-1:0]   ctr_row,
  output logic            ctr_step,
  output logic            evt,
  output cyc_kind_e       kind,
  output logic            rfsh,
  output logic [AW-1:0]   row_q,
  output logic [AW-1:0]   col_q,
  output logic            wr_pulse,
  output logic [DQ_W-1:0] wr_dq,
  output logic            rd_active,
  output logic            tm
);
  phase_e ph;
  logic ras_p, cas_p, we_p;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;

  assign ras_fall = ras_p & ~ras;
  assign ras_rise = ~ras_p & ras;
  assign cas_fall = cas_p & ~cas;
  assign cas_rise = ~cas_p & cas;
  assign we_fall  = we_p & ~we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; ras_p <= 1'b1; cas_p <= 1'b1; we_p <= 1'b1;
      evt <= 1'b0; kind <= CYC_ACCESS; rfsh <= 1'b0; ctr_step <= 1'b0;
      row_q <= '0; col_q <= '0; wr_pulse <= 1'b0; wr_dq <= '0;
      rd_active <= 1'b0; tm <= 1'b0;
    end else begin
      ras_p <= ras; cas_p <= cas; we_p <= we;
      evt <= 1'b0; rfsh <= 1'b0; ctr_step <= 1'b0; wr_pulse <= 1'b0;
      if (cas_rise) rd_active <= 1'b0;
      case (ph)
        PH_IDLE: if (ras_fall) begin
          if (cas) begin
            row_q <= addr; ph <= PH_ROW;
          end else if (we) begin
            evt <= 1'b1; kind <= CYC_CNTREF; rfsh <= 1'b1;
            row_q <= ctr_row; ctr_step <= 1'b1; tm <= 1'b0;
            ph <= PH_CNT_LOW;
          end else begin
            evt <= 1'b1; kind <= CYC_TSET; tm <= 1'b1; ph <= PH_TSET;
          end
        end
        PH_ROW: if (ras_rise) begin
          evt <= 1'b1; kind <= CYC_ROWREF; rfsh <= 1'b1; tm <= 1'b0;
          ph <= PH_IDLE;
        end else if (cas_fall) begin
          evt <= 1'b1; kind <= CYC_ACCESS; ph <= PH_ACC;
          col_q <= addr;
          if (!we) begin wr_pulse <= 1'b1; wr_dq <= dq; rd_active <= 1'b0; end
          else rd_active <= 1'b1;
        end
        PH_ACC: if (ras_rise) ph <= PH_IDLE;
          else if (cas_fall) begin
            col_q <= addr;
            if (!we) begin wr_pulse <= 1'b1; wr_dq <= dq; rd_active <= 1'b0; end
            else rd_active <= 1'b1;
          end else if (we_fall && !cas) begin
            wr_pulse <= 1'b1; wr_dq <= dq;
          end
        PH_CNT_LOW: if (ras_rise) ph <= PH_IDLE;
          else if (cas_rise) ph <= PH_CNT_HIGH;
        PH_CNT_HIGH: if (ras_rise) ph <= PH_IDLE;
          else if (cas_fall) begin
            ph <= PH_ACC; col_q <= addr;
            if (!we) begin wr_pulse <= 1'b1; wr_dq <= dq; rd_active <= 1'b0; end
            else rd_active <= 1'b1;
          end
        PH_TSET: if (ras_rise) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  a_r1_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  a_r3_tset_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && kind == CYC_TSET) |-> tm);
  a_r4_ref_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && (kind == CYC_ROWREF || kind == CYC_CNTREF)) |-> !tm);
  a_r5_rfsh_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh |-> (evt && kind != CYC_ACCESS && kind != CYC_TSET));
endmodule

// File: rtl/test_datapath.sv
module test_datapath #(
  parameter int DQ_W  = 4,
  parameter int GRP   = 8,
  parameter int T_BIT = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tm,
  input  logic            rd_active,
  input  logic [GRP-1:0]  rd_word,
  input  logic            wr_pulse,
  input  logic [DQ_W-1:0] wr_dq,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe,
  output logic [GRP-1:0]  wr_en,
  output logic [GRP-1:0]  wr_data
);
  localparam logic [GRP-1:0] NORM_MASK = GRP'((1 << DQ_W) - 1);
  logic pass;

  assign pass  = (&rd_word) | ~(|rd_word);
  assign dq_oe = rd_active;

  always_comb begin
    if (!rd_active) dq_out = '0;
    else if (tm) dq_out = {DQ_W{pass}};
    else dq_out = rd_word[DQ_W-1:0];
    wr_en   = '0;
    wr_data = '0;
    if (wr_pulse) begin
      if (tm) begin
        wr_en   = '1;
        wr_data = {GRP{wr_dq[T_BIT]}};
      end else begin
        wr_en   = NORM_MASK;
        wr_data = GRP'(wr_dq);
      end
    end
  end

  a_r7_hiz_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == '0);
  a_r10_tm_write_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en && tm) |-> (wr_data == '0 || wr_data == '1));
endmodule

// File: rtl/strobe_mode_ctrl.sv
module strobe_mode_ctrl
  import strobe_mode_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DQ_W  = 4,
  parameter int GRP   = 8,
  parameter int T_BIT = 1,
  parameter int SYNC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            row_strobe_n,
  input  logic            col_strobe_n,
  input  logic            wr_strobe_n,
  input  logic [AW-1:0]   addr,
  input  logic [DQ_W-1:0] dq_in,
  input  logic [GRP-1:0]  rd_word,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe,
  output logic [AW-1:0]   arr_row,
  output logic [AW-1:0]   arr_col,
  output logic [GRP-1:0]  wr_en,
  output logic [GRP-1:0]  wr_data,
  output logic            rfsh_stb,
  output logic            cyc_evt,
  output logic [1:0]      cyc_kind,
  output logic            test_mode
);
  localparam int DW = AW + DQ_W;

  logic [2:0]      strb_s;
  logic [DW-1:0]   data_s;
  logic [AW-1:0]   ctr_row;
  logic            ctr_step, wr_pulse, rd_active;
  logic [DQ_W-1:0] wr_dq;
  cyc_kind_e       kind;

  strobe_sync #(.W(3), .STAGES(SYNC), .RST_V(1'b1)) u_sync_strb (
    .clk(clk), .rst_n(rst_n),
    .d({row_strobe_n, col_strobe_n, wr_strobe_n}), .q(strb_s));

  strobe_sync #(.W(DW), .STAGES(SYNC), .RST_V(1'b0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(data_s));

  refresh_ctr #(.ROW_W(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(ctr_step), .row(ctr_row));

  cycle_fsm #(.AW(AW), .DQ_W(DQ_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ras(strb_s[2]), .cas(strb_s[1]), .we(strb_s[0]),
    .addr(data_s[DW-1:DQ_W]), .dq(data_s[DQ_W-1:0]),
    .ctr_row(ctr_row), .ctr_step(ctr_step),
    .evt(cyc_evt), .kind(kind), .rfsh(rfsh_stb),
    .row_q(arr_row), .col_q(arr_col),
    .wr_pulse(wr_pulse), .wr_dq(wr_dq),
    .rd_active(rd_active), .tm(test_mode));

  test_datapath #(.DQ_W(DQ_W), .GRP(GRP), .T_BIT(T_BIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .tm(test_mode), .rd_active(rd_active),
    .rd_word(rd_word), .wr_pulse(wr_pulse), .wr_dq(wr_dq),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_en(wr_en), .wr_data(wr_data));

  assign cyc_kind = kind;

  a_r8_write_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en && $rose(cyc_evt)) |-> !dq_oe);
endmodule

// File: tb/strobe_mode_ctrl_tb.sv
`timescale 1ns/1ps
module strobe_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [7:0] rd_word = '0;
  logic [3:0] dq_out;
  logic dq_oe, rfsh_stb, cyc_evt, test_mode;
  logic [9:0] arr_row, arr_col;
  logic [7:0] wr_en, wr_data;
  logic [1:0] cyc_kind;

  int checks = 0, fails = 0;
  int evt_n = 0, rf_n = 0, wr_n = 0;
  logic [1:0] last_kind;
  logic [9:0] last_rf_row;
  logic [7:0] last_en, last_data;
  logic [9:0] model_ctr = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobe_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .row_strobe_n(ras_n), .col_strobe_n(cas_n),
    .wr_strobe_n(we_n), .addr(addr), .dq_in(dq_in), .rd_word(rd_word),
    .dq_out(dq_out), .dq_oe(dq_oe), .arr_row(arr_row), .arr_col(arr_col),
    .wr_en(wr_en), .wr_data(wr_data), .rfsh_stb(rfsh_stb), .cyc_evt(cyc_evt),
    .cyc_kind(cyc_kind), .test_mode(test_mode));

  always @(negedge clk) begin
    if (cyc_evt) begin evt_n++; last_kind = cyc_kind; end
    if (rfsh_stb) begin rf_n++; last_rf_row = arr_row; end
    if (|wr_en) begin wr_n++; last_en = wr_en; last_data = wr_data; end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_strb(logic r, logic c, logic w);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w;
    settle();
  endtask

  function automatic logic [3:0] exp_rd(bit tm, logic [7:0] w);
    if (!tm) return w[3:0];
    return ((w == 8'h00) || (w == 8'hFF)) ? 4'hF : 4'h0;
  endfunction

  function automatic logic [7:0] exp_wdata(bit tm, logic [3:0] d);
    if (tm) return {8{d[1]}};
    return {4'h0, d};
  endfunction

  task automatic do_cntref(string tag);
    int e0, r0;
    e0 = evt_n; r0 = rf_n;
    set_strb(1, 0, 1);
    set_strb(0, 0, 1);
    check({tag, " R1 evt"}, evt_n - e0, 1);
    check({tag, " R1 kind"}, last_kind, 2);
    check({tag, " R2 rfsh"}, rf_n - r0, 1);
    check({tag, " R2 row"}, last_rf_row, model_ctr);
    model_ctr++;
  endtask

  task automatic release_all();
    set_strb(1, 1, 1);
  endtask

  task automatic access(string tag, bit tm, logic [9:0] row, logic [9:0] col,
                        bit wr, logic [3:0] d, logic [7:0] rw);
    int w0;
    w0 = wr_n;
    @(negedge clk); addr = row;
    set_strb(0, 1, 1);
    check({tag, " R6 row"}, arr_row, row);
    @(negedge clk); addr = col; dq_in = d; rd_word = rw;
    set_strb(0, 0, wr ? 1'b0 : 1'b1);
    check({tag, " R6 col"}, arr_col, col);
    if (wr) begin
      check({tag, " R8 wr count"}, wr_n - w0, 1);
      check({tag, " R8/R10 wr_en"}, last_en, tm ? 8'hFF : 8'h0F);
      check({tag, " R8/R10 wr_data"}, last_data, exp_wdata(tm, d));
      check({tag, " R8 oe off"}, dq_oe, 0);
    end else begin
      check({tag, " R7 oe"}, dq_oe, 1);
      check({tag, " R7/R9 dq"}, dq_out, exp_rd(tm, rw));
    end
    release_all();
  endtask

  initial begin
    int e0, r0, w0;
    logic [9:0] rr;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R12 test_mode", test_mode, 0);
    check("R12 dq_oe", dq_oe, 0);
    check("R12 wr_en", wr_en, 0);
    check("R12 evt", cyc_evt, 0);
    rst_n = 1'b1;
    settle();
    check("R12 no evt", evt_n, 0);

    do_cntref("first cntref R12");
    release_all();
    do_cntref("second cntref");
    release_all();

    // R6/R7 page-mode read
    @(negedge clk); addr = 10'h155;
    set_strb(0, 1, 1);
    @(negedge clk); addr = 10'h0A3; rd_word = 8'h5C;
    e0 = evt_n;
    set_strb(0, 0, 1);
    check("R1 access evt", evt_n - e0, 1);
    check("R1 access kind", last_kind, 0);
    check("R7 dq", dq_out, 4'hC);
    set_strb(0, 1, 1);
    check("R7 oe off at col high", dq_oe, 0);
    check("R7 dq zero", dq_out, 0);
    @(negedge clk); addr = 10'h3F0;
    set_strb(0, 0, 1);
    check("R6 page col", arr_col, 10'h3F0);
    check("R6 page row", arr_row, 10'h155);
    check("R1 page no new evt", evt_n - e0, 1);
    // R8 delayed write
    @(negedge clk); dq_in = 4'h9;
    w0 = wr_n;
    set_strb(0, 0, 0);
    check("R8 delayed wr", wr_n - w0, 1);
    check("R8 delayed data", last_data, 8'h09);
    release_all();

    access("early write", 0, 10'h211, 10'h017, 1, 4'h6, 8'h00);

    // R5 row-only refresh
    @(negedge clk); addr = 10'h2C7;
    e0 = evt_n; r0 = rf_n;
    set_strb(0, 1, 1);
    check("R5 no evt before rise", evt_n - e0, 0);
    set_strb(1, 1, 1);
    check("R5 evt", evt_n - e0, 1);
    check("R5 kind", last_kind, 1);
    check("R5 rfsh row", last_rf_row, 10'h2C7);
    check("R5 rfsh count", rf_n - r0, 1);

    // R3 test-mode set
    e0 = evt_n;
    set_strb(1, 0, 0);
    set_strb(0, 0, 0);
    check("R3 kind", last_kind, 3);
    check("R3 evt", evt_n - e0, 1);
    check("R3 test_mode", test_mode, 1);
    release_all();

    access("tm read zeros R9", 1, 10'h010, 10'h020, 0, 4'h0, 8'h00);
    access("tm read ones R9", 1, 10'h011, 10'h021, 0, 4'h0, 8'hFF);
    access("tm read mixed R9", 1, 10'h012, 10'h022, 0, 4'h0, 8'h80);
    access("tm write one R10", 1, 10'h013, 10'h023, 1, 4'h2, 8'h00);
    access("tm write zero R10", 1, 10'h014, 10'h024, 1, 4'hD, 8'h00);
    check("R4 access keeps tm", test_mode, 1);

    for (int i = 0; i < 12; i++) begin
      logic [7:0] pw;
      pw = (i % 3 == 0) ? 8'hFF : 8'($urandom);
      access("tm random R9/R10", 1, 10'($urandom), 10'($urandom),
             bit'($urandom % 2), 4'($urandom), pw);
    end

    // R4 exit by row-only refresh
    @(negedge clk); addr = 10'h001;
    set_strb(0, 1, 1);
    set_strb(1, 1, 1);
    check("R4 exit row-only", test_mode, 0);

    // R4 exit by counter refresh
    set_strb(1, 0, 0);
    set_strb(0, 0, 0);
    check("R3 re-enter", test_mode, 1);
    release_all();
    do_cntref("exit cntref");
    check("R4 exit cntref", test_mode, 0);

    // R11 counter-test access in the same row-strobe low period
    rr = model_ctr - 1'b1;
    set_strb(0, 1, 1);
    @(negedge clk); addr = 10'h1E5; rd_word = 8'hA7;
    e0 = evt_n;
    set_strb(0, 0, 1);
    check("R11 row", arr_row, rr);
    check("R11 col", arr_col, 10'h1E5);
    check("R11 dq", dq_out, 4'h7);
    check("R11 no extra evt", evt_n - e0, 0);
    release_all();

    for (int i = 0; i < 20; i++)
      access("random normal R6/R7/R8", 0, 10'($urandom), 10'($urandom),
             bit'($urandom % 2), 4'($urandom), 8'($urandom));

    // R2 wrap
    while (model_ctr != 10'h3FF) begin
      @(negedge clk); ras_n = 1; cas_n = 0; we_n = 1; repeat (3) @(negedge clk);
      ras_n = 0; repeat (3) @(negedge clk);
      ras_n = 1; repeat (3) @(negedge clk);
      cas_n = 1; repeat (3) @(negedge clk);
      model_ctr++;
    end
    do_cntref("row 1023 R2");
    release_all();
    do_cntref("wrap row 0 R2");
    release_all();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule